// File: doc/BRIEF.md
# Bidirectional Timer Count Core

This block is the counting heart of a general-purpose timer. It holds an up/down count of configurable width (eight bits by default). The count moves by one on each accepted timer tick. Ticks come from a set of prescaler tap strobes, and a 3-bit select field picks which strobe, if any, is used. Control inputs enable counting, set the direction and request a clear. A clear takes effect on an accepted tick and forces the count to zero.

A processor port can load the count at any time, whether or not ticks are arriving. A load wins over any clear or step in the same cycle. The current count is always visible on a read port.

Two registered outputs show when the count is at its largest value and when it is at zero. A sticky overflow flag records the end of a counting period. In the plain wrap mode, the end of a period is an upward step out of the largest value. In the sweep mode, it is a downward step that lands on zero. Software clears the flag by writing a one to it. A set event in the same cycle beats that clear.

Top module: `tmr_count_core`

## Requirements
- R1: A tick is accepted only when `clk_sel` is nonzero and bit `clk_sel-1` of `tap_strobe` is high. With `clk_sel` = 0, or with the selected bit low, the count holds, whatever the other tap bits are.
- R2: On an accepted tick with `cnt_en` = 1 and `cnt_clr` = 0, the count moves by one: up when `cnt_down` = 0 and down when `cnt_down` = 1. It wraps modulo 2^WIDTH, so 0xFF goes up to 0x00 and 0x00 goes down to 0xFF.
- R3: On an accepted tick with `cnt_clr` = 1, the count becomes zero, whatever `cnt_en` is. Without an accepted tick, `cnt_clr` has no effect.
- R4: `cpu_wr` = 1 loads `cpu_wdata` into the count on the next edge, with or without a tick. It takes priority over clear and step. A load never sets the overflow flag.
- R5: `at_max` is 1 exactly when the count is all ones. `at_bottom` is 1 exactly when the count is zero. Both change on the same edge as the count.
- R6: With `sweep_mode` = 0, the overflow flag sets on a step upward from the all-ones value. A downward wrap does not set it.
- R7: With `sweep_mode` = 1, the overflow flag sets on a step downward from 1 to 0. Wraps in either direction do not set it.
- R8: `ovf_clr` = 1 clears the overflow flag on the next edge, unless a set event occurs in that cycle. In that case the flag is 1.
- R9: Synchronous active-high `rst` gives a count of 0, `at_bottom` = 1, `at_max` = 0 and overflow = 0.
- R10: With `cnt_en` = 0 and `cnt_clr` = 0, an accepted tick leaves the count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_strobe | input | 7 | Prescaler tap strobes; bit k is picked by select value k+1 |
| clk_sel | input | 3 | Tick source select; 0 stops the counter |
| cnt_en | input | 1 | Step enable |
| cnt_down | input | 1 | Direction: 0 up, 1 down |
| cnt_clr | input | 1 | Clear request, acted on at an accepted tick |
| sweep_mode | input | 1 | Overflow rule: 0 wrap mode, 1 sweep mode |
| cpu_wr | input | 1 | Load strobe for the count |
| cpu_wdata | input | 8 | Value to load |
| ovf_clr | input | 1 | Write-one-to-clear for the overflow flag |
| cpu_rdata | output | 8 | Current count |
| at_max | output | 1 | Count is all ones |
| at_bottom | output | 1 | Count is zero |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
The hardest cases to reach from the ports are those where several actions compete in one cycle. A load can arrive together with a tick, a clear and a step. A set event can arrive together with a flag clear. Getting there takes two steps: a load first places the count on the edge value (0xFF, or 1 in sweep mode), and the next vector then drives every competing input at once.

A vector table exercises these cases with hand-derived expected values. It also covers the tap selection with strobes on unselected taps and wraps in both directions under each overflow rule. A reset applied in the middle of the run completes the checks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_LOAD  = 2'd1,
    ACT_CLEAR = 2'd2,
    ACT_STEP  = 2'd3
  } tmr_act_e;
endpackage

// File: rtl/tmr_tick_sel.sv
module tmr_tick_sel #(
  parameter int SEL_W = 3,
  parameter int NTAPS = (1 << SEL_W) - 1
) (
  input  logic [NTAPS-1:0] taps,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [NTAPS-1:0] hit;

  // Select value k+1 routes tap k; select 0 routes nothing.
  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    assign hit[k] = taps[k] && (sel == SEL_W'(k + 1));
  end

  assign tick = |hit;

  always_comb begin
    a_r1_one_hot_pick: assert ($onehot0(hit));
  end
endmodule

// File: rtl/tmr_cnt_path.sv
module tmr_cnt_path
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             en,
  input  logic             down,
  input  logic             clr,
  input  logic             wr,
  input  logic [WIDTH-1:0] wdata,
  output tmr_act_e         act,
  output logic [WIDTH-1:0] cnt_q,
  output logic [WIDTH-1:0] cnt_nxt
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Priority: bus load, then clear, then step.
  always_comb begin
    if (wr)              act = ACT_LOAD;
    else if (tick && clr) act = ACT_CLEAR;
    else if (tick && en)  act = ACT_STEP;
    else                  act = ACT_HOLD;
  end

  always_comb begin
    unique case (act)
      ACT_LOAD:  cnt_nxt = wdata;
      ACT_CLEAR: cnt_nxt = '0;
      ACT_STEP:  cnt_nxt = down ? cnt_q - ONE : cnt_q + ONE;
      default:   cnt_nxt = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_nxt;
  end

  // R4: a load lands on the next edge regardless of other controls
  a_r4_load_wins: assert property (@(posedge clk) disable iff (rst)
    wr |=> cnt_q == $past(wdata));

  // R1: without a tick and without a load the count holds
  a_r1_no_tick_hold: assert property (@(posedge clk) disable iff (rst)
    (!tick && !wr) |=> $stable(cnt_q));

  // R3: clear on a tick without a load yields zero
  a_r3_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && clr && !wr) |=> cnt_q == '0);
endmodule

// File: rtl/tmr_ext_flags.sv
module tmr_ext_flags
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  tmr_act_e         act,
  input  logic             down,
  input  logic             sweep,
  input  logic [WIDTH-1:0] cnt_q,
  input  logic [WIDTH-1:0] cnt_nxt,
  input  logic             flag_clr,
  output logic             at_max,
  output logic             at_bottom,
  output logic             ovf
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic ovf_set;

  // Wrap mode: up step out of the top. Sweep mode: down step landing at zero.
  always_comb begin
    ovf_set = 1'b0;
    if (act == ACT_STEP) begin
      if (sweep) ovf_set = down && (cnt_q == ONE);
      else       ovf_set = !down && (cnt_q == TOP);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      at_max    <= 1'b0;
      at_bottom <= 1'b1;
      ovf       <= 1'b0;
    end else begin
      at_max    <= (cnt_nxt == TOP);
      at_bottom <= (cnt_nxt == '0);
      if (ovf_set)       ovf <= 1'b1;
      else if (flag_clr) ovf <= 1'b0;
    end
  end

  // R5: the two extreme indications never coexist
  a_r5_extremes_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(at_max && at_bottom));

  // R6/R7: a set event is visible on the next edge
  a_r6_set_seen: assert property (@(posedge clk) disable iff (rst)
    ovf_set |=> ovf);

  // R8: a clear with no competing set empties the flag
  a_r8_clear_seen: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && !ovf_set) |=> !ovf);

  // R4: a load never raises the flag
  a_r4_load_no_flag: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_LOAD && !ovf) |=> !ovf);
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int SEL_W = 3,
  parameter int NTAPS = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NTAPS-1:0] tap_strobe,
  input  logic [SEL_W-1:0] clk_sel,
  input  logic             cnt_en,
  input  logic             cnt_down,
  input  logic             cnt_clr,
  input  logic             sweep_mode,
  input  logic             cpu_wr,
  input  logic [WIDTH-1:0] cpu_wdata,
  input  logic             ovf_clr,
  output logic [WIDTH-1:0] cpu_rdata,
  output logic             at_max,
  output logic             at_bottom,
  output logic             ovf_flag
);
  logic             tick;
  tmr_act_e         act;
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_nxt;

  tmr_tick_sel #(.SEL_W(SEL_W), .NTAPS(NTAPS)) u_sel (
    .taps (tap_strobe),
    .sel  (clk_sel),
    .tick (tick)
  );

  tmr_cnt_path #(.WIDTH(WIDTH)) u_path (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .en      (cnt_en),
    .down    (cnt_down),
    .clr     (cnt_clr),
    .wr      (cpu_wr),
    .wdata   (cpu_wdata),
    .act     (act),
    .cnt_q   (cnt_q),
    .cnt_nxt (cnt_nxt)
  );

  tmr_ext_flags #(.WIDTH(WIDTH)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .down      (cnt_down),
    .sweep     (sweep_mode),
    .cnt_q     (cnt_q),
    .cnt_nxt   (cnt_nxt),
    .flag_clr  (ovf_clr),
    .at_max    (at_max),
    .at_bottom (at_bottom),
    .ovf       (ovf_flag)
  );

  assign cpu_rdata = cnt_q;

  // R10: disabled, uncleared, unloaded cycles leave the count alone
  a_r10_disabled_hold: assert property (@(posedge clk) disable iff (rst)
    (!cnt_en && !cnt_clr && !cpu_wr) |=> $stable(cpu_rdata));
endmodule

// File: tb/tb_tmr_count_core.sv
module tb_tmr_count_core;
  typedef struct packed {
    logic [3:0] req;
    logic       wr;
    logic [7:0] wd;
    logic [2:0] sel;
    logic [6:0] taps;
    logic       en;
    logic       dn;
    logic       clr;
    logic       md;
    logic       fc;
    logic [7:0] ecnt;
    logic       emax;
    logic       ebot;
    logic       eovf;
  } vec_t;

  localparam int NV = 28;
  // Each row: requirement, stimulus, then count/max/bottom/overflow after one edge.
  localparam vec_t VECS [NV] = '{
    '{4'd2,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R2 up
    '{4'd1,  1'b0, 8'h00, 3'd1, 7'b0000000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R1 no strobe
    '{4'd1,  1'b0, 8'h00, 3'd0, 7'b1111111, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R1 stopped
    '{4'd1,  1'b0, 8'h00, 3'd3, 7'b0000100, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0}, // R1 tap 3
    '{4'd1,  1'b0, 8'h00, 3'd3, 7'b0000010, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0}, // R1 wrong tap
    '{4'd2,  1'b0, 8'h00, 3'd7, 7'b1000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R2 down
    '{4'd5,  1'b0, 8'h00, 3'd7, 7'b1000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R5 bottom
    '{4'd6,  1'b0, 8'h00, 3'd7, 7'b1000000, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0}, // R6 down wrap no flag
    '{4'd6,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}, // R6 up wrap flag
    '{4'd8,  1'b0, 8'h00, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}, // R8 clear flag
    '{4'd4,  1'b1, 8'h80, 3'd1, 7'b0000001, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0}, // R4 load over all
    '{4'd3,  1'b0, 8'h00, 3'd2, 7'b0000010, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R3 clear on tick
    '{4'd4,  1'b1, 8'h55, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0}, // R4 load stopped
    '{4'd3,  1'b0, 8'h00, 3'd2, 7'b0000000, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 8'h55, 1'b0, 1'b0, 1'b0}, // R3 clear no tick
    '{4'd3,  1'b0, 8'h00, 3'd2, 7'b0000010, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R3 clear en=0
    '{4'd5,  1'b1, 8'hFF, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0}, // R5 max
    '{4'd8,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1}, // R8 set wins
    '{4'd4,  1'b1, 8'hFF, 3'd1, 7'b0000001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b1}, // R4 load keeps flag
    '{4'd8,  1'b0, 8'h00, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hFF, 1'b1, 1'b0, 1'b0}, // R8 clear
    '{4'd7,  1'b1, 8'h02, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h02, 1'b0, 1'b0, 1'b0}, // R7 preload
    '{4'd7,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h01, 1'b0, 1'b0, 1'b0}, // R7 down
    '{4'd7,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1}, // R7 land zero
    '{4'd8,  1'b0, 8'h00, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0, 1'b1, 1'b0}, // R8 clear
    '{4'd7,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 1'b1, 1'b0, 1'b0}, // R7 down wrap
    '{4'd7,  1'b0, 8'h00, 3'd1, 7'b0000001, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R7 up wrap
    '{4'd10, 1'b0, 8'h00, 3'd1, 7'b0000001, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0}, // R10 disabled
    '{4'd4,  1'b1, 8'h7F, 3'd0, 7'b0000000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h7F, 1'b0, 1'b0, 1'b0}, // R4 load
    '{4'd2,  1'b0, 8'h00, 3'd5, 7'b0010000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h80, 1'b0, 1'b0, 1'b0}  // R2 carry
  };

  logic       clk = 1'b0;
  logic       rst;
  logic [6:0] tap_strobe;
  logic [2:0] clk_sel;
  logic       cnt_en, cnt_down, cnt_clr, sweep_mode, cpu_wr, ovf_clr;
  logic [7:0] cpu_wdata;
  logic [7:0] cpu_rdata;
  logic       at_max, at_bottom, ovf_flag;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tmr_count_core dut (
    .clk(clk), .rst(rst), .tap_strobe(tap_strobe), .clk_sel(clk_sel),
    .cnt_en(cnt_en), .cnt_down(cnt_down), .cnt_clr(cnt_clr),
    .sweep_mode(sweep_mode), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .ovf_clr(ovf_clr), .cpu_rdata(cpu_rdata), .at_max(at_max),
    .at_bottom(at_bottom), .ovf_flag(ovf_flag)
  );

  task automatic idle();
    tap_strobe = '0; clk_sel = '0; cnt_en = 0; cnt_down = 0; cnt_clr = 0;
    sweep_mode = 0; cpu_wr = 0; cpu_wdata = '0; ovf_clr = 0;
  endtask

  task automatic check(input string tag, input logic [7:0] ec,
                       input logic em, input logic eb, input logic eo);
    n_chk++;
    if (cpu_rdata !== ec || at_max !== em || at_bottom !== eb || ovf_flag !== eo) begin
      n_fail++;
      $display("FAIL %s: got cnt=%h max=%b bot=%b ovf=%b, expected cnt=%h max=%b bot=%b ovf=%b",
               tag, cpu_rdata, at_max, at_bottom, ovf_flag, ec, em, eb, eo);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R9 reset state", 8'h00, 1'b0, 1'b1, 1'b0);

    for (int i = 0; i < NV; i++) begin
      cpu_wr = VECS[i].wr;   cpu_wdata = VECS[i].wd;
      clk_sel = VECS[i].sel; tap_strobe = VECS[i].taps;
      cnt_en = VECS[i].en;   cnt_down = VECS[i].dn;
      cnt_clr = VECS[i].clr; sweep_mode = VECS[i].md;
      ovf_clr = VECS[i].fc;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            VECS[i].ecnt, VECS[i].emax, VECS[i].ebot, VECS[i].eovf);
    end

    // R9: reset in mid-run with the flag set and a nonzero count
    idle();
    cpu_wr = 1; cpu_wdata = 8'hFF;
    @(negedge clk);
    idle();
    clk_sel = 3'd1; tap_strobe = 7'b0000001; cnt_en = 1;
    @(negedge clk);
    check("R6 flag before reset", 8'h00, 1'b0, 1'b1, 1'b1);
    idle();
    cpu_wr = 1; cpu_wdata = 8'hAB;
    @(negedge clk);
    rst = 1'b1;
    idle();
    @(negedge clk);
    rst = 1'b0;
    check("R9 mid-run reset", 8'h00, 1'b0, 1'b1, 1'b0);

    // R1: every select value picks exactly its own tap
    for (int s = 1; s < 8; s++) begin
      idle();
      cpu_wr = 1; cpu_wdata = 8'h10;
      @(negedge clk);
      idle();
      clk_sel = 3'(s); tap_strobe = ~(7'b1 << (s - 1)); cnt_en = 1;
      @(negedge clk);
      check($sformatf("R1 sel %0d others only", s), 8'h10, 1'b0, 1'b0, 1'b0);
      tap_strobe = 7'b1 << (s - 1);
      @(negedge clk);
      check($sformatf("R1 sel %0d own tap", s), 8'h11, 1'b0, 1'b0, 1'b0);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule